// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the modem status byte of a serial port controller. It watches four incoming handshake lines: clear-to-send, data-set-ready, ring and carrier detect. For each line it holds the present level and a sticky flag that records a change. The byte goes to the register read path. A single pending output tells the interrupt encoder that at least one change flag is set.

External lines pass through a two-flop synchroniser before they are compared. When the loopback control bit is set, the four lines are taken from the modem control outputs instead of the pins:

- request-to-send feeds clear-to-send.
- terminal-ready feeds data-set-ready.
- auxiliary output 1 feeds ring.
- auxiliary output 2 feeds carrier detect.

The control levels are compared every cycle. Writing new control values, or entering or leaving loopback, takes effect on the next clock edge and can raise change flags.

A read strobe returns the current byte in the cycle it is high. On the following edge it clears the four flags. The level bits are left as they are.

Top module: `modem_status_unit`

## Requirements
- R1: In the cycle after a synchronous reset, `msr_q` is 0x30 (clear-to-send and data-set-ready high, no flags) and `delta_pend` is 0. The external pins are assumed to rest at clear-to-send=1, data-set-ready=1, ring=0, carrier=0.
- R2: A pin change that is set up before rising edge k appears in `msr_q` after edge k+2 and not before, because of the two-flop synchroniser.
- R3: Byte layout: bits 7..4 hold the levels of carrier, ring, data-set-ready and clear-to-send (bit 7 carrier, bit 4 clear-to-send); bits 3..0 hold the matching flags. Any change of clear-to-send, data-set-ready or carrier updates its level bit and sets its flag (bit 0, 1 or 3).
- R4: The ring flag (bit 2) is set only when ring goes from 0 to 1. A fall from 1 to 0 updates bit 6 but sets no flag.
- R5: A flag stays set, however many cycles pass, until a read.
- R6: While `msr_rd` is high, `msr_q` shows the current byte. After that edge, bits 3..0 are zero unless a new change arrived, and bits 7..4 are unchanged.
- R7: A change that lands on the same edge as a read sets its flag, and the flag stays set after the read.
- R8: When `mcr_loop` is 1, the levels follow the mapping rts→bit 4, dtr→bit 5, out1→bit 6, out2→bit 7, one edge after the control inputs change, and pin changes have no effect. When `mcr_loop` is 0, the control outputs have no effect on `msr_q`.
- R9: Entering or leaving loopback sets the flag of every line whose level differs between the two sources, following the rules in R3 and R4.
- R10: `delta_pend` is 1 exactly when any of bits 3..0 of `msr_q` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | External clear-to-send, asynchronous |
| dsr_pin | input | 1 | External data-set-ready, asynchronous |
| ri_pin | input | 1 | External ring indicator, asynchronous |
| dcd_pin | input | 1 | External carrier detect, asynchronous |
| mcr_dtr | input | 1 | Terminal-ready control output |
| mcr_rts | input | 1 | Request-to-send control output |
| mcr_out1 | input | 1 | Auxiliary control output 1 |
| mcr_out2 | input | 1 | Auxiliary control output 2 |
| mcr_loop | input | 1 | Loopback select |
| msr_rd | input | 1 | Read strobe of the status byte, one cycle per read |
| msr_q | output | 8 | Status byte: levels in 7..4, flags in 3..0 |
| delta_pend | output | 1 | Any flag set, to the interrupt encoder |

## Verification
The assertions assume that a read strobe lasts one cycle per access. They also assume the control inputs come from registers in the same clock domain, so the loopback mapping can be checked one edge after any control value. Pins may change at any time in operation. The stimulus changes a pin only when the previous change on that line has already passed the synchroniser, and it places reads on edges computed from the three-register pin path. Because of this, each expected byte, including the case where a change and a read land on the same edge, is known exactly.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  typedef enum int {LN_CTS = 0, LN_DSR = 1, LN_RI = 2, LN_DCD = 3} line_e;
  // Level of each line after reset, bit i = line i
  localparam logic [NLINES-1:0] LINE_RST = 4'b0011;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_line.sv
module mdm_line #(
  parameter logic RST_ST = 1'b0,
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic rd_clr,
  output logic st_q,
  output logic flg_q,
  output logic flg_d
);
  logic chg, set_flag;

  always_comb begin
    chg = src ^ st_q;
    set_flag = RISE_ONLY ? (chg & src) : chg;
    // a new event wins over a concurrent read-clear
    flg_d = set_flag | (flg_q & ~rd_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RST_ST;
      flg_q <= 1'b0;
    end else begin
      st_q  <= src;
      flg_q <= flg_d;
    end
  end

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flg_q && !rd_clr) |=> flg_q); // R5
  AST_FLAG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_q) |-> !$stable(st_q)); // R3
  AST_CHANGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!RISE_ONLY && !$stable(st_q)) |-> flg_q); // R3
  AST_RING_RISE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (RISE_ONLY && $rose(st_q)) |-> flg_q); // R4
  AST_RING_FALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (RISE_ONLY && $fell(st_q) && $past(rd_clr)) |-> !flg_q); // R4
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_pin,
  input  logic       dsr_pin,
  input  logic       ri_pin,
  input  logic       dcd_pin,
  input  logic       mcr_dtr,
  input  logic       mcr_rts,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       mcr_loop,
  input  logic       msr_rd,
  output logic [7:0] msr_q,
  output logic       delta_pend
);
  logic [NLINES-1:0] pin_raw, pin_s, loop_src, src;
  logic [NLINES-1:0] st, flg, flg_nxt;
  logic              pend_q;

  assign pin_raw  = {dcd_pin, ri_pin, dsr_pin, cts_pin};
  assign loop_src = {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
  );

  assign src = mcr_loop ? loop_src : pin_s;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    mdm_line #(.RST_ST(LINE_RST[i]), .RISE_ONLY(i == LN_RI)) u_line (
      .clk(clk), .rst(rst), .src(src[i]), .rd_clr(msr_rd),
      .st_q(st[i]), .flg_q(flg[i]), .flg_d(flg_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= |flg_nxt;
  end

  assign msr_q      = {st, flg};
  assign delta_pend = pend_q;

  AST_PEND_OR: assert property (@(posedge clk) disable iff (rst)
    delta_pend == (|msr_q[3:0])); // R10
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |=> (msr_q[7:4] == $past({mcr_out2, mcr_out1, mcr_dtr, mcr_rts}))); // R8
  AST_READ_KEEPS_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && $stable(src)) |=> $stable(msr_q[7:4])); // R6
endmodule

// File: tb/tb_modem_status_unit.sv
`timescale 1ns/100ps
module tb_modem_status_unit;
  logic clk = 0, rst = 1;
  logic cts_pin = 1, dsr_pin = 1, ri_pin = 0, dcd_pin = 0;
  logic mcr_dtr = 0, mcr_rts = 0, mcr_out1 = 0, mcr_out2 = 0, mcr_loop = 0;
  logic msr_rd = 0;
  logic [7:0] msr_q;
  logic delta_pend;
  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  modem_status_unit dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_st(string tag, logic [7:0] exp);
    chk(tag, msr_q, exp);
    chk({tag, " pend"}, {7'd0, delta_pend}, {7'd0, |exp[3:0]});
  endtask

  task automatic negs(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one-cycle read, expected byte pushed to scoreboard
  task automatic do_read(string tag, logic [7:0] exp);
    msr_rd = 1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    msr_rd = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (msr_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", msr_q, 8'hxx);
      else chk(tag_q.pop_front(), msr_q, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    negs(3); rst = 0; negs(1);
    chk_st("R1 reset", 8'h30);
    // R2/R3 carrier rises
    dcd_pin = 1; negs(2);
    chk_st("R2 not yet", 8'h30);
    negs(1);
    chk_st("R3 dcd change", 8'hB8);
    do_read("R6 read value", 8'hB8);
    chk_st("R6 flags cleared", 8'hB0);
    cts_pin = 0; negs(3);
    chk_st("R3 cts change", 8'hA1);
    do_read("R6 read cts", 8'hA1);
    chk_st("R6 after read", 8'hA0);
    // R4 ring
    ri_pin = 1; negs(3);
    chk_st("R4 ring rise", 8'hE4);
    do_read("R4 read ring", 8'hE4);
    ri_pin = 0; negs(3);
    chk_st("R4 ring fall no flag", 8'hA0);
    // R5 sticky
    dsr_pin = 0; negs(3);
    chk_st("R3 dsr change", 8'h82);
    negs(10);
    chk_st("R5 sticky", 8'h82);
    // R7 change on the read edge
    cts_pin = 1; negs(2);
    do_read("R7 read before change", 8'h82);
    chk_st("R7 flag kept", 8'h91);
    do_read("R7 read", 8'h91);
    chk_st("R7 cleared", 8'h90);
    // R9/R8 loopback
    mcr_rts = 0; mcr_dtr = 1; mcr_out1 = 0; mcr_out2 = 1; mcr_loop = 1;
    negs(1);
    chk_st("R9 enter loop", 8'hA3);
    do_read("R9 read", 8'hA3);
    dcd_pin = 0; negs(4);
    chk_st("R8 pins ignored", 8'hA0);
    mcr_out1 = 1; negs(1);
    chk_st("R8 out1 to ring", 8'hE4);
    mcr_rts = 1; negs(1);
    chk_st("R8 rts to cts", 8'hF5);
    do_read("R8 read", 8'hF5);
    chk_st("R8 after read", 8'hF0);
    mcr_loop = 0; negs(1);
    chk_st("R9 leave loop", 8'h1A);
    do_read("R9 read leave", 8'h1A);
    chk_st("R10 pend clear", 8'h10);
    mcr_rts = 0; mcr_dtr = 0; mcr_out2 = 0; negs(4);
    chk_st("R8 mcr ignored", 8'h10);
    negs(2);
    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule